// File: doc/BRIEF.md
# Tag-Steered Constant-Multiply Accumulate Cell

This block is one processing element of a linear systolic array that evaluates cyclic and pseudo-cyclic convolutions. Each cell owns one fixed coefficient and two running partial sums, called the first and second accumulation paths. Operands and control tags enter at one side of the cell and leave, delayed, at the other side. This lets a chain of identical cells share data and control without any global wiring.

Every clock cycle the source tag selects one operand pair, either the primary pair or the alternate pair. Each selected operand is multiplied by the cell's coefficient. The sign tag decides whether the first path subtracts or adds its product. The second path has a fixed sign chosen at build time: the head cell of an array adds, and every other cell subtracts.

No hardware multiplier is used. Each operand is split into its even-indexed and odd-indexed bits, and the two halves address the two read ports of a small table of precomputed coefficient products. The odd-half result is doubled and added to the even-half result. A weighted table entry then corrects for the two's-complement sign bit. The cell is a four-stage pipeline: operand selection, table access, merge, and accumulate. It accepts a new input set every cycle.

Top module: `tagged_lut_pe`

## Requirements
- R1: The four operand inputs (primary and alternate operand for each path) appear unchanged on their outputs exactly 4 clock cycles after they are sampled.
- R2: Both tags (`src_i`, `neg_i`) appear unchanged on `src_o` and `neg_o` 4 cycles after they are sampled.
- R3: When `src_i` is 1, the first path uses `a1_i` and the second path uses `a2_i`. When `src_i` is 0, the first path uses `a1_alt_i` and the second path uses `a2_alt_i`.
- R4: When `neg_i` is 1, `acc1_o` equals `acc1_i` minus the product. When `neg_i` is 0, it equals `acc1_i` plus the product.
- R5: With `FIRST_CELL`=1, `acc2_o` equals `acc2_i` plus the product. With `FIRST_CELL`=0, it equals `acc2_i` minus the product. `neg_i` has no effect on this path.
- R6: The product equals COEF multiplied by the operand read as a signed two's-complement number, with no error. This holds for every operand value, including the most negative one, zero, -1 and the largest positive value.
- R7: Each accumulate result appears 4 cycles after its inputs are sampled. A new independent input set is accepted on every cycle.
- R8: A synchronous active-high `rst` clears every output to zero at the next clock edge.
- R9: Each accumulation is carried out modulo 2^YW, so a sum or difference that overflows wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a1_i | input | XW | Primary operand, first path |
| a1_alt_i | input | XW | Alternate operand, first path |
| a2_i | input | XW | Primary operand, second path |
| a2_alt_i | input | XW | Alternate operand, second path |
| acc1_i | input | YW | Incoming partial sum, first path |
| acc2_i | input | YW | Incoming partial sum, second path |
| src_i | input | 1 | Source tag: 1 selects the primary operands |
| neg_i | input | 1 | Sign tag for the first path: 1 subtracts |
| a1_o | output | XW | Forwarded `a1_i` |
| a1_alt_o | output | XW | Forwarded `a1_alt_i` |
| a2_o | output | XW | Forwarded `a2_i` |
| a2_alt_o | output | XW | Forwarded `a2_alt_i` |
| acc1_o | output | YW | Updated partial sum, first path |
| acc2_o | output | YW | Updated partial sum, second path |
| src_o | output | 1 | Forwarded source tag |
| neg_o | output | 1 | Forwarded sign tag |

## Verification
Every output, whether a forwarded operand, a forwarded tag or an updated partial sum, is due exactly four clock edges after its inputs are sampled. The bench keeps the last eight input sets in a ring indexed by cycle number. It drives new inputs on the falling edge, and on each falling edge it compares the outputs with the set driven four falling edges earlier. Comparisons start only once four sets have been driven since the last reset release. The reset check reads the outputs one falling edge after `rst` is raised, because the reset takes effect at the single rising edge in between.

// File: rtl/pe_cell_pkg.sv
package pe_cell_pkg;

    // Direction in which a path folds its product into the running sum.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } acc_op_e;

endpackage

// File: rtl/pe_half_lut.sv
// Dual-read-port table of coefficient products. Entry a holds COEF times
// the value obtained by placing bit j of a at bit position 2j.
module pe_half_lut #(
    parameter int HW   = 4,
    parameter int TW   = 16,
    parameter int COEF = 91
) (
    input  logic [HW-1:0]        addr_a_i,
    input  logic [HW-1:0]        addr_b_i,
    output logic signed [TW-1:0] data_a_o,
    output logic signed [TW-1:0] data_b_o,
    output logic signed [TW-1:0] msb_w_o
);
    localparam int DEPTH = 1 << HW;

    function automatic int spread(input int a);
        int r;
        r = 0;
        for (int j = 0; j < HW; j++) begin
            if (a[j]) r += (1 << (2 * j));
        end
        return r;
    endfunction

    logic signed [TW-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam int VAL = COEF * spread(g);
        assign rom[g] = TW'(VAL);
    end

    assign data_a_o = rom[addr_a_i];
    assign data_b_o = rom[addr_b_i];
    // Entry for the top half-bit alone, used for sign correction.
    assign msb_w_o  = rom[DEPTH/2];

endmodule

// File: rtl/pe_merge.sv
// Rebuilds the full constant product from the two half-word lookups.
// The odd half carries twice the weight of the even half. The top odd bit is
// the two's-complement sign bit: its table weight is positive, so four times
// its entry is taken away to give it a negative weight.
module pe_merge #(
    parameter int TW = 16,
    parameter int YW = 20
) (
    input  logic signed [TW-1:0] even_i,
    input  logic signed [TW-1:0] odd_i,
    input  logic signed [TW-1:0] msb_w_i,
    input  logic                 sign_bit_i,
    output logic signed [YW-1:0] prod_o
);
    logic signed [YW-1:0] even_x, odd_x, msb_x, fix;

    always_comb begin
        even_x = YW'(even_i);
        odd_x  = YW'(odd_i);
        msb_x  = YW'(msb_w_i);
        fix    = sign_bit_i ? (msb_x <<< 2) : '0;
        prod_o = even_x + (odd_x <<< 1) - fix;
    end

endmodule

// File: rtl/tagged_lut_pe.sv
module tagged_lut_pe #(
    parameter int XW         = 8,
    parameter int CW         = 8,
    parameter int YW         = 20,
    parameter int COEF       = 91,
    parameter bit FIRST_CELL = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [XW-1:0] a1_i,
    input  logic [XW-1:0] a1_alt_i,
    input  logic [XW-1:0] a2_i,
    input  logic [XW-1:0] a2_alt_i,
    input  logic [YW-1:0] acc1_i,
    input  logic [YW-1:0] acc2_i,
    input  logic          src_i,
    input  logic          neg_i,
    output logic [XW-1:0] a1_o,
    output logic [XW-1:0] a1_alt_o,
    output logic [XW-1:0] a2_o,
    output logic [XW-1:0] a2_alt_o,
    output logic [YW-1:0] acc1_o,
    output logic [YW-1:0] acc2_o,
    output logic          src_o,
    output logic          neg_o
);
    import pe_cell_pkg::*;

    localparam int HW    = XW / 2;
    localparam int TW    = CW + XW;
    localparam int DEPTH = 4;
    localparam int NPATH = 2;

    typedef struct packed {
        logic [XW-1:0] a1;
        logic [XW-1:0] a1a;
        logic [XW-1:0] a2;
        logic [XW-1:0] a2a;
        logic          src;
        logic          neg;
    } fwd_t;

    typedef struct packed {
        logic [2:0]                     age;
        fwd_t [DEPTH-1:0]               fwd;
        // stage 1: operand selection
        logic [NPATH-1:0][XW-1:0]       s1_op;
        logic [NPATH-1:0][YW-1:0]       s1_acc;
        logic                           s1_neg;
        // stage 2: table access
        logic [NPATH-1:0][TW-1:0]       s2_even;
        logic [NPATH-1:0][TW-1:0]       s2_odd;
        logic [NPATH-1:0][TW-1:0]       s2_msbw;
        logic [NPATH-1:0]               s2_sign;
        logic [NPATH-1:0][YW-1:0]       s2_acc;
        logic                           s2_neg;
        // stage 3: product merge
        logic [NPATH-1:0][YW-1:0]       s3_prod;
        logic [NPATH-1:0][YW-1:0]       s3_acc;
        logic                           s3_neg;
        // stage 4: accumulate
        logic [NPATH-1:0][YW-1:0]       s4_acc;
    } pipe_t;

    pipe_t cur_q, nxt_d;

    logic [NPATH-1:0][HW-1:0]        even_addr, odd_addr;
    logic signed [NPATH-1:0][TW-1:0] lut_even, lut_odd, lut_msbw;
    logic signed [NPATH-1:0][YW-1:0] merged;

    always_comb begin
        for (int p = 0; p < NPATH; p++) begin
            for (int j = 0; j < HW; j++) begin
                even_addr[p][j] = cur_q.s1_op[p][2*j];
                odd_addr[p][j]  = cur_q.s1_op[p][2*j+1];
            end
        end
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        logic signed [TW-1:0] e_w, o_w, m_w;
        logic signed [YW-1:0] prod_w;

        pe_half_lut #(.HW(HW), .TW(TW), .COEF(COEF)) u_lut (
            .addr_a_i (even_addr[p]),
            .addr_b_i (odd_addr[p]),
            .data_a_o (e_w),
            .data_b_o (o_w),
            .msb_w_o  (m_w)
        );

        pe_merge #(.TW(TW), .YW(YW)) u_merge (
            .even_i     (cur_q.s2_even[p]),
            .odd_i      (cur_q.s2_odd[p]),
            .msb_w_i    (cur_q.s2_msbw[p]),
            .sign_bit_i (cur_q.s2_sign[p]),
            .prod_o     (prod_w)
        );

        assign lut_even[p] = e_w;
        assign lut_odd[p]  = o_w;
        assign lut_msbw[p] = m_w;
        assign merged[p]   = prod_w;
    end

    acc_op_e op_d [NPATH];

    always_comb begin
        nxt_d = cur_q;

        if (cur_q.age != 3'd4) nxt_d.age = cur_q.age + 3'd1;

        nxt_d.fwd[0] = '{a1: a1_i, a1a: a1_alt_i, a2: a2_i, a2a: a2_alt_i,
                         src: src_i, neg: neg_i};
        for (int s = 1; s < DEPTH; s++) nxt_d.fwd[s] = cur_q.fwd[s-1];

        nxt_d.s1_op[0]  = src_i ? a1_i : a1_alt_i;
        nxt_d.s1_op[1]  = src_i ? a2_i : a2_alt_i;
        nxt_d.s1_acc[0] = acc1_i;
        nxt_d.s1_acc[1] = acc2_i;
        nxt_d.s1_neg    = neg_i;

        for (int p = 0; p < NPATH; p++) begin
            nxt_d.s2_even[p] = lut_even[p];
            nxt_d.s2_odd[p]  = lut_odd[p];
            nxt_d.s2_msbw[p] = lut_msbw[p];
            nxt_d.s2_sign[p] = cur_q.s1_op[p][XW-1];
            nxt_d.s3_prod[p] = merged[p];
        end
        nxt_d.s2_acc = cur_q.s1_acc;
        nxt_d.s2_neg = cur_q.s1_neg;
        nxt_d.s3_acc = cur_q.s2_acc;
        nxt_d.s3_neg = cur_q.s2_neg;

        op_d[0] = cur_q.s3_neg ? OP_SUB : OP_ADD;
        op_d[1] = FIRST_CELL ? OP_ADD : OP_SUB;
        for (int p = 0; p < NPATH; p++) begin
            nxt_d.s4_acc[p] = (op_d[p] == OP_SUB)
                            ? cur_q.s3_acc[p] - cur_q.s3_prod[p]
                            : cur_q.s3_acc[p] + cur_q.s3_prod[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign a1_o     = cur_q.fwd[DEPTH-1].a1;
    assign a1_alt_o = cur_q.fwd[DEPTH-1].a1a;
    assign a2_o     = cur_q.fwd[DEPTH-1].a2;
    assign a2_alt_o = cur_q.fwd[DEPTH-1].a2a;
    assign src_o    = cur_q.fwd[DEPTH-1].src;
    assign neg_o    = cur_q.fwd[DEPTH-1].neg;
    assign acc1_o   = cur_q.s4_acc[0];
    assign acc2_o   = cur_q.s4_acc[1];

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    function automatic logic [YW-1:0] mac_ref(input logic [YW-1:0] acc,
                                              input logic [XW-1:0] x,
                                              input logic          sub);
        logic [YW-1:0] p;
        p = YW'($signed(x) * COEF);
        return sub ? acc - p : acc + p;
    endfunction

    // R1
    a_r1_operands_pass: assert property (@(posedge clk) disable iff (rst)
        (cur_q.age == 3'd4) |-> (a1_o == $past(a1_i, 4)) && (a1_alt_o == $past(a1_alt_i, 4))
                             && (a2_o == $past(a2_i, 4)) && (a2_alt_o == $past(a2_alt_i, 4)));

    // R2
    a_r2_tags_follow: assert property (@(posedge clk) disable iff (rst)
        (cur_q.age == 3'd4) |-> (src_o == $past(src_i, 4)) && (neg_o == $past(neg_i, 4)));

    // R3, R4, R7
    a_r4_acc1_signed: assert property (@(posedge clk) disable iff (rst)
        (cur_q.age == 3'd4) |-> acc1_o == mac_ref($past(acc1_i, 4),
            $past(src_i, 4) ? $past(a1_i, 4) : $past(a1_alt_i, 4), $past(neg_i, 4)));

    // R5
    a_r5_acc2_fixed_sign: assert property (@(posedge clk) disable iff (rst)
        (cur_q.age == 3'd4) |-> acc2_o == mac_ref($past(acc2_i, 4),
            $past(src_i, 4) ? $past(a2_i, 4) : $past(a2_alt_i, 4), !FIRST_CELL));

    // R6: merged table product against the operand two stages earlier
    a_r6_exact_product: assert property (@(posedge clk) disable iff (rst)
        (cur_q.age >= 3'd3) |-> (cur_q.s3_prod[0] == YW'($signed($past(cur_q.s1_op[0], 2)) * COEF))
                             && (cur_q.s3_prod[1] == YW'($signed($past(cur_q.s1_op[1], 2)) * COEF)));

    // R8
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (acc1_o == '0) && (acc2_o == '0) && (a1_o == '0) && !src_o && !neg_o);

endmodule

// File: tb/tb_tagged_lut_pe.sv
`timescale 1ns/1ps
module tb_tagged_lut_pe;
    localparam int XW   = 8;
    localparam int CW   = 8;
    localparam int YW   = 20;
    localparam int COEF = -77;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [XW-1:0] a1, a1a, a2, a2a;
    logic [YW-1:0] acc1, acc2;
    logic src, neg;

    logic [XW-1:0] a1_o, a1a_o, a2_o, a2a_o, n_a1_o, n_a1a_o, n_a2_o, n_a2a_o;
    logic [YW-1:0] acc1_o, acc2_o, n_acc1_o, n_acc2_o;
    logic src_o, neg_o, n_src_o, n_neg_o;

    always #10 clk = ~clk;

    tagged_lut_pe #(.XW(XW), .CW(CW), .YW(YW), .COEF(COEF), .FIRST_CELL(1'b1)) dut (
        .clk(clk), .rst(rst), .a1_i(a1), .a1_alt_i(a1a), .a2_i(a2), .a2_alt_i(a2a),
        .acc1_i(acc1), .acc2_i(acc2), .src_i(src), .neg_i(neg),
        .a1_o(a1_o), .a1_alt_o(a1a_o), .a2_o(a2_o), .a2_alt_o(a2a_o),
        .acc1_o(acc1_o), .acc2_o(acc2_o), .src_o(src_o), .neg_o(neg_o));

    tagged_lut_pe #(.XW(XW), .CW(CW), .YW(YW), .COEF(COEF), .FIRST_CELL(1'b0)) dut_neg (
        .clk(clk), .rst(rst), .a1_i(a1), .a1_alt_i(a1a), .a2_i(a2), .a2_alt_i(a2a),
        .acc1_i(acc1), .acc2_i(acc2), .src_i(src), .neg_i(neg),
        .a1_o(n_a1_o), .a1_alt_o(n_a1a_o), .a2_o(n_a2_o), .a2_alt_o(n_a2a_o),
        .acc1_o(n_acc1_o), .acc2_o(n_acc2_o), .src_o(n_src_o), .neg_o(n_neg_o));

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int live   = 0;
    bit done   = 1'b0;

    logic [XW-1:0] h_a1 [8], h_a1a [8], h_a2 [8], h_a2a [8];
    logic [YW-1:0] h_acc1 [8], h_acc2 [8];
    logic          h_src [8], h_neg [8];

    function automatic logic [YW-1:0] model(input logic [YW-1:0] acc,
                                            input logic [XW-1:0] x,
                                            input logic sub);
        int xv, pv;
        xv = int'($signed(x));
        pv = xv * COEF;
        return sub ? acc - YW'(pv) : acc + YW'(pv);
    endfunction

    task automatic check(input string req, input logic [YW-1:0] act, input logic [YW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic compare_due();
        int k;
        logic [XW-1:0] op1, op2;
        k   = (cyc - 4) & 7;
        op1 = h_src[k] ? h_a1[k] : h_a1a[k];
        op2 = h_src[k] ? h_a2[k] : h_a2a[k];
        check("R1 a1 forward",     YW'(a1_o),  YW'(h_a1[k]));
        check("R1 a1 alt forward", YW'(a1a_o), YW'(h_a1a[k]));
        check("R1 a2 forward",     YW'(a2_o),  YW'(h_a2[k]));
        check("R1 a2 alt forward", YW'(a2a_o), YW'(h_a2a[k]));
        check("R2 src tag",        YW'(src_o), YW'(h_src[k]));
        check("R2 neg tag",        YW'(neg_o), YW'(h_neg[k]));
        // R3 R4 R6 R7 R9: selected operand, sign, exact product, latency, wrap
        check("R3 R4 R6 R7 R9 acc1", acc1_o, model(h_acc1[k], op1, h_neg[k]));
        check("R3 R4 acc1 non-head cell", n_acc1_o, model(h_acc1[k], op1, h_neg[k]));
        check("R5 acc2 head cell adds", acc2_o, model(h_acc2[k], op2, 1'b0));
        check("R5 acc2 other cell subtracts", n_acc2_o, model(h_acc2[k], op2, 1'b1));
    endtask

    task automatic step(input logic [XW-1:0] v1, input logic [XW-1:0] v1a,
                        input logic [XW-1:0] v2, input logic [XW-1:0] v2a,
                        input logic [YW-1:0] y1, input logic [YW-1:0] y2,
                        input logic t_src, input logic t_neg);
        int k;
        @(negedge clk);
        if (live >= 4) compare_due();
        rst = 1'b0;
        a1 = v1; a1a = v1a; a2 = v2; a2a = v2a;
        acc1 = y1; acc2 = y2; src = t_src; neg = t_neg;
        k = cyc & 7;
        h_a1[k] = v1; h_a1a[k] = v1a; h_a2[k] = v2; h_a2a[k] = v2a;
        h_acc1[k] = y1; h_acc2[k] = y2; h_src[k] = t_src; h_neg[k] = t_neg;
        cyc++;
        live++;
    endtask

    task automatic random_step();
        step(XW'($urandom), XW'($urandom), XW'($urandom), XW'($urandom),
             YW'($urandom), YW'($urandom), 1'($urandom), 1'($urandom));
    endtask

    task automatic check_reset_zero();
        check("R8 acc1 cleared", acc1_o, '0);
        check("R8 acc2 cleared", acc2_o, '0);
        check("R8 a1 cleared", YW'(a1_o), '0);
        check("R8 tags cleared", YW'({src_o, neg_o}), '0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        a1 = '0; a1a = '0; a2 = '0; a2a = '0; acc1 = '0; acc2 = '0; src = 1'b0; neg = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_zero();

        // R6 corners on primary operands, R3 alt operands differ
        step(8'h80, 8'h11, 8'h80, 8'h22, 20'h00100, 20'h00200, 1'b1, 1'b0);
        step(8'h80, 8'h11, 8'h7F, 8'h22, 20'h00100, 20'h00200, 1'b1, 1'b1);
        step(8'h7F, 8'h80, 8'hFF, 8'h00, 20'h00000, 20'h00000, 1'b1, 1'b0);
        step(8'h00, 8'hFF, 8'h01, 8'h80, 20'h12345, 20'h54321, 1'b1, 1'b1);
        // R3 alternate operands selected
        step(8'h55, 8'h80, 8'h33, 8'h7F, 20'h00010, 20'h00020, 1'b0, 1'b0);
        step(8'h55, 8'hFF, 8'h33, 8'h01, 20'h00010, 20'h00020, 1'b0, 1'b1);
        // R9 wrap: large positive plus positive product, zero minus positive product
        step(8'h80, 8'h00, 8'h80, 8'h00, 20'h7FFFF, 20'hFFFF0, 1'b1, 1'b0);
        step(8'h80, 8'h00, 8'h80, 8'h00, 20'h00000, 20'h00005, 1'b1, 1'b1);
        step(8'hC3, 8'h3C, 8'hAA, 8'h5A, 20'hFFFFF, 20'h80000, 1'b0, 1'b1);

        for (int i = 0; i < 300; i++) random_step();

        // R8 mid-stream reset with a full pipeline
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset_zero();
        live = 0;

        for (int i = 0; i < 100; i++) random_step();
        for (int i = 0; i < 4; i++) random_step();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule